// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block performs the arithmetic and logic work of an 8-bit accumulator processor for the instruction group whose opcode ends in binary 01. The upper three opcode bits choose the operation: OR, AND, XOR, add with carry, load, compare or subtract with borrow. The block takes the opcode, the current accumulator, the operand byte just read and the current status byte. From these it forms a new accumulator value and a new status byte.

The result is computed combinationally. It is captured into output registers on a clock edge where the commit strobe is high. The sequencer raises that strobe in the cycle where the instruction's last operand read completes. While the strobe is low, the registered outputs hold their values. Opcodes outside the group, and the store slot inside it, copy the accumulator and status inputs through unchanged. Arithmetic is always binary, whatever the decimal flag holds.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_out` becomes 0x00 and `stat_out` becomes 0x20.
- R2: When `commit` is high at a clock edge, `acc_out` and `stat_out` take the new result at that edge. When `commit` is low, both outputs keep their previous values.
- R3: The ALU acts only when `opcode[1:0]` is 01. `opcode[7:5]` selects the operation: 0 = OR, 1 = AND, 2 = XOR, 3 = add with carry, 5 = load, 6 = compare, 7 = subtract with borrow. OR, AND, XOR and load write the result to the accumulator and change only N and Z.
- R4: Whenever N and Z are updated, N equals bit 7 of the 8-bit result and Z is 1 exactly when that result is 0x00.
- R5: Add with carry forms the 9-bit sum `acc_in + operand + C`, where C is `stat_in[0]`. It writes bits 7:0 to the accumulator, sets C to bit 8 of the sum, and updates N, Z and V.
- R6: Subtract with borrow forms `acc_in + ~operand + C`, with C taken from `stat_in[0]`. It writes bits 7:0 to the accumulator, sets C to bit 8 of the sum, and updates N, Z and V.
- R7: Compare forms `acc_in + ~operand + 1` and updates N, Z and C. The accumulator output equals `acc_in`, and V is copied from `stat_in[6]`.
- R8: V is set exactly when bit 7 of `(sum ^ acc_in) & (sum ^ b)` is 1, where b is the second adder input: the operand for add, its complement for subtract.
- R9: The status byte layout is C = bit 0, Z = bit 1, I = bit 2, D = bit 3, B = bit 4, constant one = bit 5, V = bit 6, N = bit 7. On commit, bits 4:2 are copied from `stat_in`, and bit 5 of `stat_out` is always 1.
- R10: For opcode group 4 (store) and for any opcode with `opcode[1:0]` other than 01, a commit gives `acc_out = acc_in` and `stat_out = stat_in | 0x20`.
- R11: The D flag has no effect on the result. For example, add 0x09 + 0x01 with D set gives 0x0A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| commit | input | 1 | Captures the computed result at this edge |
| opcode | input | 8 | Instruction opcode byte |
| acc_in | input | 8 | Current accumulator value |
| operand | input | 8 | Operand byte fetched for the instruction |
| stat_in | input | 8 | Current status byte |
| acc_out | output | 8 | Registered accumulator result |
| stat_out | output | 8 | Registered status result |

## Verification
Each result appears at the first rising edge where `commit` is high, one register stage after the inputs settle, and it stays until the next commit. The bench drives inputs and the strobe on the falling edge, lets one rising edge capture them, and drops the strobe on the next falling edge. It compares the outputs at that point, so every check sees exactly one capture. Hold behaviour is checked by changing every input with the strobe low and confirming at the following falling edge that nothing moved.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int OPW = 8;
    localparam int SW  = 8;

    // status byte bit positions (other logic decodes these)
    localparam int SB_C   = 0;
    localparam int SB_Z   = 1;
    localparam int SB_I   = 2;
    localparam int SB_D   = 3;
    localparam int SB_B   = 4;
    localparam int SB_ONE = 5;
    localparam int SB_V   = 6;
    localparam int SB_N   = 7;

    localparam logic [1:0] GRP_ALU = 2'b01;
    localparam int         OPSEL_LO = 5;
    localparam int         OPSEL_W  = 3;

    typedef enum logic [OPSEL_W-1:0] {
        OP_OR  = 3'd0,
        OP_AND = 3'd1,
        OP_XOR = 3'd2,
        OP_ADC = 3'd3,
        OP_STO = 3'd4,
        OP_LD  = 3'd5,
        OP_CMP = 3'd6,
        OP_SBC = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic    active;
        alu_op_e op;
        logic    wr_acc;
        logic    upd_nz;
        logic    upd_c;
        logic    upd_v;
        logic    invert_b;
        logic    cin_one;
        logic    use_adder;
    } alu_ctl_t;

    typedef struct packed {
        logic n;
        logic v;
        logic z;
        logic c;
    } alu_flags_t;

    function automatic logic is_zero(input logic [DW-1:0] x);
        return (x == '0);
    endfunction

    function automatic logic [SW-1:0] merge_status(
        input logic [SW-1:0] old_st,
        input alu_ctl_t      ctl,
        input alu_flags_t    f
    );
        logic [SW-1:0] s;
        s = old_st;
        if (ctl.upd_nz) begin
            s[SB_N] = f.n;
            s[SB_Z] = f.z;
        end
        if (ctl.upd_c) s[SB_C] = f.c;
        if (ctl.upd_v) s[SB_V] = f.v;
        s[SB_ONE] = 1'b1;
        return s;
    endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OPW-1:0] opcode,
    output alu_ctl_t       ctl
);

    alu_op_e sel;
    assign sel = alu_op_e'(opcode[OPSEL_LO +: OPSEL_W]);

    always_comb begin
        ctl = '0;
        ctl.op = sel;
        if (opcode[1:0] == GRP_ALU) begin
            ctl.active = 1'b1;
            unique case (sel)
                OP_OR, OP_AND, OP_XOR, OP_LD: begin
                    ctl.wr_acc = 1'b1;
                    ctl.upd_nz = 1'b1;
                end
                OP_ADC: begin
                    ctl.wr_acc    = 1'b1;
                    ctl.upd_nz    = 1'b1;
                    ctl.upd_c     = 1'b1;
                    ctl.upd_v     = 1'b1;
                    ctl.use_adder = 1'b1;
                end
                OP_SBC: begin
                    ctl.wr_acc    = 1'b1;
                    ctl.upd_nz    = 1'b1;
                    ctl.upd_c     = 1'b1;
                    ctl.upd_v     = 1'b1;
                    ctl.invert_b  = 1'b1;
                    ctl.use_adder = 1'b1;
                end
                OP_CMP: begin
                    ctl.upd_nz    = 1'b1;
                    ctl.upd_c     = 1'b1;
                    ctl.invert_b  = 1'b1;
                    ctl.cin_one   = 1'b1;
                    ctl.use_adder = 1'b1;
                end
                default: begin
                    ctl.active = 1'b0;   // store slot: no ALU effect
                end
            endcase
        end
    end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
    import acc_alu_pkg::*;
(
    input  alu_ctl_t       ctl,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  m,
    input  logic           c_flag,
    output logic [DW-1:0]  res,
    output alu_flags_t     flags
);

    logic [DW-1:0] b_in;
    logic          cin;
    logic [DW:0]   sum;
    logic [DW-1:0] logic_res;

    assign b_in = ctl.invert_b ? ~m : m;
    assign cin  = ctl.cin_one ? 1'b1 : c_flag;
    assign sum  = {1'b0, a} + {1'b0, b_in} + {{DW{1'b0}}, cin};

    always_comb begin
        unique case (ctl.op)
            OP_OR:   logic_res = a | m;
            OP_AND:  logic_res = a & m;
            OP_XOR:  logic_res = a ^ m;
            OP_LD:   logic_res = m;
            default: logic_res = a;
        endcase
    end

    assign res     = ctl.use_adder ? sum[DW-1:0] : logic_res;
    assign flags.n = res[DW-1];
    assign flags.z = is_zero(res);
    assign flags.c = sum[DW];
    assign flags.v = (sum[DW-1] ^ a[DW-1]) & (sum[DW-1] ^ b_in[DW-1]);

    // R8: overflow only possible when both adder inputs share a sign
    always_comb begin
        if (ctl.use_adder && (a[DW-1] != b_in[DW-1]))
            assert_no_overflow_R8: assert (flags.v == 1'b0);
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           commit,
    input  logic [OPW-1:0] opcode,
    input  logic [DW-1:0]  acc_in,
    input  logic [DW-1:0]  operand,
    input  logic [SW-1:0]  stat_in,
    output logic [DW-1:0]  acc_out,
    output logic [SW-1:0]  stat_out
);

    localparam logic [SW-1:0] STAT_RST = SW'(1) << SB_ONE;

    alu_ctl_t      ctl;
    logic [DW-1:0] res;
    alu_flags_t    flg;
    logic [DW-1:0] acc_nxt;
    logic [SW-1:0] stat_nxt;

    acc_alu_decode u_dec (
        .opcode (opcode),
        .ctl    (ctl)
    );

    acc_alu_core u_core (
        .ctl    (ctl),
        .a      (acc_in),
        .m      (operand),
        .c_flag (stat_in[SB_C]),
        .res    (res),
        .flags  (flg)
    );

    assign acc_nxt  = ctl.wr_acc ? res : acc_in;
    assign stat_nxt = merge_status(stat_in, ctl, flg);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_out  <= '0;
            stat_out <= STAT_RST;
        end else if (commit) begin
            acc_out  <= acc_nxt;
            stat_out <= stat_nxt;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> ($stable(acc_out) && $stable(stat_out)));

    assert_cmp_keeps_acc_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && opcode[1:0] == GRP_ALU && opcode[7:5] == 3'd6)
        |=> (acc_out == $past(acc_in) && stat_out[SB_V] == $past(stat_in[SB_V])));

    assert_n_z_R4: assert property (@(posedge clk) disable iff (rst)
        (commit && opcode[1:0] == GRP_ALU && opcode[7:5] != 3'd4 && opcode[7:5] != 3'd6)
        |=> (stat_out[SB_N] == acc_out[DW-1] && stat_out[SB_Z] == (acc_out == '0)));

    assert_passthrough_R10: assert property (@(posedge clk) disable iff (rst)
        (commit && (opcode[1:0] != GRP_ALU || opcode[7:5] == 3'd4))
        |=> (acc_out == $past(acc_in) && stat_out == ($past(stat_in) | STAT_RST)));

    assert_ctrl_bits_R9: assert property (@(posedge clk) disable iff (rst)
        commit |=> (stat_out[SB_B:SB_I] == $past(stat_in[SB_B:SB_I]) && stat_out[SB_ONE]));

    assert_logic_keeps_cv_R3: assert property (@(posedge clk) disable iff (rst)
        (commit && opcode[1:0] == GRP_ALU && (opcode[7:5] <= 3'd2 || opcode[7:5] == 3'd5))
        |=> (stat_out[SB_C] == $past(stat_in[SB_C]) && stat_out[SB_V] == $past(stat_in[SB_V])));

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       commit;
    logic [7:0] opcode, acc_in, operand, stat_in;
    logic [7:0] acc_out, stat_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u_dut (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .opcode   (opcode),
        .acc_in   (acc_in),
        .operand  (operand),
        .stat_in  (stat_in),
        .acc_out  (acc_out),
        .stat_out (stat_out)
    );

    task automatic check(input string req, input logic [7:0] got_a, input logic [7:0] exp_a,
                         input logic [7:0] got_s, input logic [7:0] exp_s);
        checks++;
        if (got_a !== exp_a || got_s !== exp_s) begin
            fails++;
            $display("FAIL %s: acc=%02h stat=%02h expected acc=%02h stat=%02h",
                     req, got_a, got_s, exp_a, exp_s);
        end
    endtask

    // one capture: drive at falling edge, capture at rising edge, sample at next falling edge
    task automatic run_op(input logic [7:0] opc, input logic [7:0] a, input logic [7:0] m,
                          input logic [7:0] st);
        @(negedge clk);
        opcode = opc; acc_in = a; operand = m; stat_in = st; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; commit = 1'b0;
        opcode = 8'h00; acc_in = 8'h00; operand = 8'h00; stat_in = 8'h00;
        repeat (2) @(negedge clk);
        check("R1 reset", acc_out, 8'h00, stat_out, 8'h20);
        rst = 1'b0;
    endtask

    task automatic t_logic;
        run_op(8'h09, 8'hF0, 8'h0F, 8'h41);   // OR, C and V kept
        check("R3 OR", acc_out, 8'hFF, stat_out, 8'hE1);
        run_op(8'h29, 8'hF0, 8'h0F, 8'h00);   // AND -> zero
        check("R4 AND zero", acc_out, 8'h00, stat_out, 8'h22);
        run_op(8'h49, 8'hAA, 8'h55, 8'h80);   // XOR
        check("R3 XOR", acc_out, 8'hFF, stat_out, 8'hA0);
        run_op(8'hA9, 8'h33, 8'h7E, 8'h82);   // LOAD clears N,Z
        check("R3 LOAD", acc_out, 8'h7E, stat_out, 8'h20);
    endtask

    task automatic t_add;
        run_op(8'h69, 8'hFF, 8'h01, 8'h00);   // 0x100: C=1 Z=1
        check("R5 ADC carry out", acc_out, 8'h00, stat_out, 8'h23);
        run_op(8'h69, 8'h10, 8'h20, 8'h01);   // carry in from status
        check("R5 ADC carry in", acc_out, 8'h31, stat_out, 8'h20);
        run_op(8'h69, 8'h50, 8'h50, 8'h00);   // signed overflow
        check("R8 ADC overflow", acc_out, 8'hA0, stat_out, 8'hE0);
    endtask

    task automatic t_sub;
        run_op(8'hE9, 8'h50, 8'h10, 8'h01);   // 0x50-0x10, no borrow
        check("R6 SBC", acc_out, 8'h40, stat_out, 8'h21);
        run_op(8'hE9, 8'h50, 8'h10, 8'h00);   // borrow in
        check("R6 SBC borrow", acc_out, 8'h3F, stat_out, 8'h21);
        run_op(8'hE9, 8'h50, 8'hB0, 8'h01);   // 0x50-(-0x50) overflows
        check("R8 SBC overflow", acc_out, 8'hA0, stat_out, 8'hE0);
    endtask

    task automatic t_compare;
        run_op(8'hC9, 8'h42, 8'h42, 8'h40);   // equal, V kept
        check("R7 CMP equal", acc_out, 8'h42, stat_out, 8'h63);
        run_op(8'hC9, 8'h10, 8'h20, 8'h00);   // less than, carry ignored
        check("R7 CMP less", acc_out, 8'h10, stat_out, 8'hA0);
    endtask

    task automatic t_passthrough;
        run_op(8'h81, 8'h12, 8'hFF, 8'hC3);   // store slot
        check("R10 store unchanged", acc_out, 8'h12, stat_out, 8'hE3);
        run_op(8'h6A, 8'h34, 8'h01, 8'h01);   // other group
        check("R10 other group", acc_out, 8'h34, stat_out, 8'h21);
    endtask

    task automatic t_status_bits;
        run_op(8'h09, 8'h01, 8'h00, 8'h1C);   // I,D,B carried over
        check("R9 control bits", acc_out, 8'h01, stat_out, 8'h3C);
    endtask

    task automatic t_decimal;
        run_op(8'h69, 8'h09, 8'h01, 8'h08);   // D set, still binary
        check("R11 binary with D", acc_out, 8'h0A, stat_out, 8'h28);
    endtask

    task automatic t_hold;
        run_op(8'h09, 8'h5A, 8'h00, 8'h00);
        check("R2 commit capture", acc_out, 8'h5A, stat_out, 8'h20);
        @(negedge clk);
        opcode = 8'h69; acc_in = 8'hFF; operand = 8'hFF; stat_in = 8'hFF; commit = 1'b0;
        @(negedge clk);
        check("R2 hold without commit", acc_out, 8'h5A, stat_out, 8'h20);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_compare();
        t_passthrough();
        t_status_bits();
        t_decimal();
        t_hold();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: acc=%02h stat=%02h expected completion", acc_out, stat_out);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule